// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns stereo sample pairs into a three-wire serial audio stream: a bit clock, a word-select line that tells left from right, and a data line. Samples enter through a simple write port: software writes the left word and then the right word. Each completed pair goes into a small transmit queue. The serializer takes one pair per frame. Each frame has two 32-bit slots, left first. The sample word inside a slot is 16, 24 or 32 bits long. Bits of the slot that the word does not fill are sent as zero.

Framing is chosen by two controls. The delay control sends the MSB one bit after the word-select change, which is the standard I2S layout. With the delay control clear, the MSB starts right at the word-select change (left-justified). The right-justify control puts the word's LSB in the last bit of its slot. Right-justify overrides the delay. Two polarity controls are independent of each other: one sets the bit-clock edge on which data changes, and the other sets the word-select level used for the left slot.

The bit-clock timing comes from outside as a half-period strobe. The data side reports the queue level and a full flag. Software can therefore top the queue up, for example with zero samples, until the full flag is set. A level interrupt (half-empty or empty) and a sticky underflow flag are combined into one interrupt line. Dropping either enable resets the serializer and keeps the queued samples. Raising both again restarts at the MSB of a left slot.

Top module: `stereo_ser_tx`

## Requirements
- R1: While reset is asserted, `level_o`=0, `full_o`=0, `sd_o`=0, `uf_o`=0, and `irq_o`=0 if `irq_en`=0.
- R2: `wlen` sets the word length: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. The word is taken from the low bits of the written data. Slot bits outside the word are sent as 0.
- R3: With `first_dly`=0 and `rjust`=0, the left slot's MSB is on `sd_o` during the first bit after word-select changes to the left level.
- R4: With `first_dly`=1 and `rjust`=0, word select changes one bit before each slot's MSB, and the right word-select level covers frame bits 31 to 62.
- R5: With `rjust`=1, the word's LSB sits in the last bit of the slot and word select is not delayed.
- R6: `bclk_o` toggles once per `half_stb` pulse while running. Its idle level equals `ckp`. Data changes on the edge where `bclk_o` goes from `~ckp` to `ckp`.
- R7: `ws_o` equals `lrs` during the left slot and `~lrs` during the right slot.
- R8: The queue holds 8 pairs. A left write followed by a right write pushes one pair. `full_o` is set exactly at 8 pairs, and writes while full are ignored. `level_o` gives the number of stored pairs.
- R9: `irq_o` = `irq_en` AND (`uf_o` OR (`lvl_sel`=1 ? level is 0 : level is 4 or less)).
- R10: If a frame starts with the queue empty, that frame sends all zeros and `uf_o` is set. `uf_o` stays set until a `uf_clr` pulse, and a new underflow in the same cycle wins over the clear.
- R11: If `glob_en` or `tx_en` is low, the serializer is held idle with `sd_o`=0. Queued pairs are kept. When both enables are high again, output restarts with the MSB of a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en | input | 1 | Block-level enable |
| tx_en | input | 1 | Transmit enable; low resets the serializer |
| half_stb | input | 1 | One pulse per half bit-clock period |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 32 | Sample word (left, then right) |
| wlen | input | 2 | Word length code |
| first_dly | input | 1 | One-bit MSB delay (I2S framing) |
| rjust | input | 1 | Right-justify the word in its slot |
| ckp | input | 1 | Bit-clock polarity |
| lrs | input | 1 | Word-select level for the left slot |
| lvl_sel | input | 1 | Interrupt threshold: 0 half-empty, 1 empty |
| irq_en | input | 1 | Interrupt enable |
| uf_clr | input | 1 | Clears the underflow flag |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| full_o | output | 1 | Queue full |
| level_o | output | 4 | Stored pair count |
| irq_o | output | 1 | Interrupt |
| uf_o | output | 1 | Sticky underflow flag |

## Verification
The serializer is run with several framing setups: left-justified 16-bit, I2S 24-bit, right-justified 16-bit, 32-bit, and the reserved length code. Each pair uses distinct, asymmetric left and right words. A swapped slot, a wrong shift or a missing one-bit delay therefore shows up as a wrong data bit at a known frame position. The two polarities are tried in three combinations, including each one set on its own, so a swapped polarity connection shows up. The queue is filled past full with the serializer stopped and then drained into underflow. The interrupt threshold is checked at the levels 0, 1 and 5. The enable is dropped in the middle of a frame to check that the serializer restarts and that the stored pairs are kept.

// File: rtl/sser_pkg.sv
package sser_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      WL_16 = 2'd0,
      WL_24 = 2'd1,
      WL_32 = 2'd2,
      WL_RS = 2'd3
   } wlen_e;

   function automatic int unsigned wl_bits(input logic [1:0] code);
      case (wlen_e'(code))
         WL_16:   return 16;
         WL_24:   return 24;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/sser_fifo.sv
module sser_fifo #(
   parameter int unsigned W     = 64,
   parameter int unsigned DEPTH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [W-1:0]                  din,
   input  logic                          pop,
   output logic [W-1:0]                  head,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          full,
   output logic                          empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH+1);

   logic [AW-1:0] wp, rp;
   logic [W-1:0]  ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (push && wp == AW'(i)) q <= din;
      end
      assign ent[i] = q;
   end

   assign head  = ent[rp];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/sser_fmt.sv
module sser_fmt
   import sser_pkg::*;
#(
   parameter int unsigned SLOT_W = 32
) (
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        wlen,
   input  logic              rjust,
   output logic [SLOT_W-1:0] slot
);
   int unsigned       nb;
   logic [WORD_W-1:0] mask;
   logic [SLOT_W-1:0] ext;

   always_comb begin
      nb   = wl_bits(wlen);
      mask = (nb >= WORD_W) ? '1 : ((WORD_W'(1) << nb) - WORD_W'(1));
      ext  = SLOT_W'(word & mask);
      if (rjust) slot = ext;
      else       slot = ext << (SLOT_W - nb);
   end
endmodule

// File: rtl/sser_engine.sv
module sser_engine #(
   parameter int unsigned SLOT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  half_stb,
   input  logic                  first_dly,
   input  logic                  rjust,
   input  logic [2*SLOT_W-1:0]   frame_in,
   input  logic                  avail,
   output logic                  pop,
   output logic                  uf_set,
   output logic                  ph_o,
   output logic                  right_o,
   output logic                  sd_o
);
   localparam int unsigned FRAME = 2 * SLOT_W;
   localparam int unsigned PW    = $clog2(FRAME);

   logic             ph, started, launch, load;
   logic [PW-1:0]    pos, nxt;
   logic [FRAME-1:0] sreg;

   always_comb begin
      launch = run && half_stb && ph;
      if (!started || pos == PW'(FRAME-1)) nxt = '0;
      else                                 nxt = pos + 1'b1;
      load   = launch && (nxt == '0);
   end

   assign pop    = load && avail;
   assign uf_set = load && !avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= 1'b0;
         started <= 1'b0;
         pos     <= '0;
         sreg    <= '0;
      end else if (!run) begin
         ph      <= 1'b0;
         started <= 1'b0;
         pos     <= '0;
         sreg    <= '0;
      end else if (half_stb) begin
         ph <= ~ph;
         if (ph) begin
            started <= 1'b1;
            pos     <= nxt;
            if (load) sreg <= avail ? frame_in : '0;
            else      sreg <= {sreg[FRAME-2:0], 1'b0};
         end
      end
   end

   always_comb begin
      if (first_dly && !rjust)
         right_o = started && pos >= PW'(SLOT_W-1) && pos != PW'(FRAME-1);
      else
         right_o = started && pos >= PW'(SLOT_W);
   end

   assign ph_o = ph;
   assign sd_o = sreg[FRAME-1];
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
   import sser_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned SLOT_W = 32,
   localparam int unsigned LVL_W = $clog2(DEPTH+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  logic              tx_en,
   input  logic              half_stb,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic [1:0]        wlen,
   input  logic              first_dly,
   input  logic              rjust,
   input  logic              ckp,
   input  logic              lrs,
   input  logic              lvl_sel,
   input  logic              irq_en,
   input  logic              uf_clr,
   output logic              bclk_o,
   output logic              ws_o,
   output logic              sd_o,
   output logic              full_o,
   output logic [LVL_W-1:0]  level_o,
   output logic              irq_o,
   output logic              uf_o
);
   localparam int unsigned PAIR_W = 2 * WORD_W;
   localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("DEPTH must be a power of two of at least 2");
   if (SLOT_W < WORD_W || (SLOT_W & (SLOT_W - 1)) != 0)
      $error("SLOT_W must be a power of two not below the word width");

   logic              run, accept, push, pop, uf_set, empty, want_r, ph, right;
   logic [WORD_W-1:0] hold;
   logic [PAIR_W-1:0] head;
   logic [2*SLOT_W-1:0] frame;
   logic [LVL_W-1:0]  count;

   assign run    = glob_en && tx_en;
   assign accept = wr_en && !full_o;
   assign push   = accept && want_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_r <= 1'b0;
         hold   <= '0;
      end else if (accept) begin
         if (!want_r) hold <= wr_data;
         want_r <= ~want_r;
      end
   end

   sser_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({hold, wr_data}),
      .pop   (pop),
      .head  (head),
      .count (count),
      .full  (full_o),
      .empty (empty)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      sser_fmt #(.SLOT_W(SLOT_W)) u_fmt (
         .word  (head[(2-ch)*WORD_W-1 -: WORD_W]),
         .wlen  (wlen),
         .rjust (rjust),
         .slot  (frame[(2-ch)*SLOT_W-1 -: SLOT_W])
      );
   end

   sser_engine #(.SLOT_W(SLOT_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .half_stb  (half_stb),
      .first_dly (first_dly),
      .rjust     (rjust),
      .frame_in  (frame),
      .avail     (!empty),
      .pop       (pop),
      .uf_set    (uf_set),
      .ph_o      (ph),
      .right_o   (right),
      .sd_o      (sd_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      uf_o <= 1'b0;
      else if (uf_set) uf_o <= 1'b1;
      else if (uf_clr) uf_o <= 1'b0;
   end

   assign level_o = count;
   assign bclk_o  = ph ^ ckp;
   assign ws_o    = right ^ lrs;
   assign irq_o   = irq_en && (uf_o || (lvl_sel ? empty : (count <= HALF)));
endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned LVL_W = $clog2(DEPTH+1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glob_en,
   input logic             tx_en,
   input logic             half_stb,
   input logic             ckp,
   input logic             irq_en,
   input logic             uf_clr,
   input logic             bclk_o,
   input logic             sd_o,
   input logic [LVL_W-1:0] level_o,
   input logic             irq_o,
   input logic             uf_o
);
   logic run;
   assign run = glob_en && tx_en;

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LVL_W'(DEPTH));

   // R8
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o == $past(level_o)) || (level_o == $past(level_o) + 1'b1) ||
      (level_o == $past(level_o) - 1'b1));

   // R10
   uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_o && !uf_clr) |=> uf_o);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq_o);

   // R11
   idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sd_o);

   // R6
   bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$past(half_stb) && $stable(ckp)) |-> $stable(bclk_o));
endmodule

bind stereo_ser_tx stereo_ser_tx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .glob_en  (glob_en),
   .tx_en    (tx_en),
   .half_stb (half_stb),
   .ckp      (ckp),
   .irq_en   (irq_en),
   .uf_clr   (uf_clr),
   .bclk_o   (bclk_o),
   .sd_o     (sd_o),
   .level_o  (level_o),
   .irq_o    (irq_o),
   .uf_o     (uf_o)
);

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic glob_en = 0, tx_en = 0, half_stb = 0, wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [1:0] wlen = 2'd0;
   logic first_dly = 0, rjust = 0, ckp = 0, lrs = 0, lvl_sel = 0, irq_en = 0, uf_clr = 0;
   logic bclk_o, ws_o, sd_o, full_o, irq_o, uf_o;
   logic [3:0] level_o;

   stereo_ser_tx uut (.*);

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit chk_on = 0, stb_on = 0;
   string phase = "R1";

   // reference model state
   logic [63:0] mq[$];
   logic [31:0] m_hold;
   bit m_wr, m_ph, m_st, m_uf;
   int m_e;
   logic [63:0] m_fr;

   function automatic logic [31:0] fmt_slot(input logic [31:0] w, input logic [1:0] wl, input bit rj);
      int nb;
      logic [63:0] v;
      nb = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 24 : 32;
      v = {32'b0, w} & ((64'd1 << nb) - 64'd1);
      if (!rj) v = v << (32 - nb);
      return v[31:0];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_hold = '0; m_wr = 0; m_ph = 0; m_st = 0; m_uf = 0; m_e = 0; m_fr = '0;
      end else begin
         bit fullp, ufset;
         fullp = (mq.size() == 8);
         ufset = 0;
         if (!(glob_en && tx_en)) begin
            m_ph = 0; m_st = 0; m_e = 0; m_fr = '0;
         end else if (half_stb) begin
            if (!m_ph) m_ph = 1;
            else begin
               int ne;
               m_ph = 0;
               ne = m_st ? (m_e + 1) % 64 : 0;
               m_st = 1;
               m_e = ne;
               if (ne == 0) begin
                  if (mq.size() > 0) begin
                     logic [63:0] pr;
                     pr = mq.pop_front();
                     m_fr = {fmt_slot(pr[63:32], wlen, rjust), fmt_slot(pr[31:0], wlen, rjust)};
                  end else begin
                     m_fr = '0;
                     ufset = 1;
                  end
               end else m_fr = m_fr << 1;
            end
         end
         if (ufset) m_uf = 1;
         else if (uf_clr) m_uf = 0;
         if (wr_en && !fullp) begin
            if (!m_wr) m_hold = wr_data;
            else mq.push_back({m_hold, wr_data});
            m_wr = !m_wr;
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on && rst_n) begin
         bit isr;
         int sz;
         sz = mq.size();
         if (first_dly && !rjust) isr = m_st && m_e >= 31 && m_e != 63;
         else isr = m_st && m_e >= 32;
         chk(bclk_o == (m_ph ^ ckp), "R6", {phase, " bclk"}, bclk_o, m_ph ^ ckp);
         chk(ws_o == (isr ^ lrs), "R7", {phase, " ws"}, ws_o, isr ^ lrs);
         chk(sd_o == m_fr[63], "R2", {phase, " sd"}, sd_o, m_fr[63]);
         chk(full_o == (sz == 8), "R8", {phase, " full"}, full_o, sz == 8);
         chk(level_o == 4'(sz), "R8", {phase, " level"}, level_o, sz);
         chk(uf_o == m_uf, "R10", {phase, " uf"}, uf_o, m_uf);
         chk(irq_o == (irq_en && (m_uf || (lvl_sel ? sz == 0 : sz <= 4))), "R9",
             {phase, " irq"}, irq_o, irq_en && (m_uf || (lvl_sel ? sz == 0 : sz <= 4)));
      end
   end

   initial begin
      int c = 0;
      forever begin
         @(posedge clk); #2;
         if (stb_on) begin half_stb = (c % 2 == 0); c++; end
         else half_stb = 0;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
      step(1); wr_en = 1; wr_data = l;
      step(1); wr_data = r;
      step(1); wr_en = 0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_run();
   end

   initial begin
      step(3);
      @(negedge clk);
      // R1 reset state
      chk(level_o == 0, "R1", "reset level", level_o, 0);
      chk(full_o == 0, "R1", "reset full", full_o, 0);
      chk(sd_o == 0, "R1", "reset sd", sd_o, 0);
      chk(uf_o == 0, "R1", "reset uf", uf_o, 0);
      chk(irq_o == 0, "R1", "reset irq", irq_o, 0);
      step(1); rst_n = 1; chk_on = 1; stb_on = 1;

      phase = "R8"; glob_en = 1;
      for (int i = 0; i < 8; i++)
         push_pair(32'h8F3C_A511 + 32'h0113_5579 * i, 32'h1B2D_3C4E ^ (32'h0F0F_0F0F * i));
      step(3);
      chk(full_o == 1, "R8", "full after 8 pairs", full_o, 1);
      chk(level_o == 8, "R8", "level after 8 pairs", level_o, 8);
      push_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF);
      step(3);
      chk(level_o == 8, "R8", "write while full ignored", level_o, 8);

      phase = "R3"; tx_en = 1; step(800);
      phase = "R4"; first_dly = 1; wlen = 2'd1;
      push_pair(32'h00C0_FFEE, 32'h0012_3457); step(800);
      phase = "R5"; first_dly = 0; rjust = 1; wlen = 2'd0; step(520);
      phase = "R2"; rjust = 0; wlen = 2'd2; step(300); wlen = 2'd3; step(300);
      phase = "R6"; ckp = 1; lrs = 1; first_dly = 1;
      for (int i = 0; i < 3; i++) push_pair(32'hDEAD_0000 | i, 32'h0000_BEEF << i);
      step(600);
      ckp = 1; lrs = 0; step(300);
      phase = "R7"; ckp = 0; lrs = 1; step(600);

      phase = "R10"; step(2600);
      chk(uf_o == 1, "R10", "underflow after drain", uf_o, 1);
      chk(level_o == 0, "R10", "drained", level_o, 0);
      tx_en = 0; step(2);
      uf_clr = 1; step(1); uf_clr = 0; step(2);
      chk(uf_o == 0, "R10", "cleared by uf_clr", uf_o, 0);

      phase = "R11"; first_dly = 0; lrs = 0;
      for (int i = 0; i < 6; i++) push_pair(32'h7654_3210 + i, 32'h0246_8ACE - i);
      tx_en = 1; step(150);
      tx_en = 0; step(2);
      begin
         logic [3:0] lv;
         lv = level_o;
         chk(sd_o == 0, "R11", "sd idle when disabled", sd_o, 0);
         step(30);
         chk(level_o == lv, "R11", "queue kept while disabled", level_o, lv);
      end
      tx_en = 1; step(400);
      glob_en = 0; step(20); glob_en = 1; step(2000);
      tx_en = 0; step(2); uf_clr = 1; step(1); uf_clr = 0; step(2);

      phase = "R9"; irq_en = 1; lvl_sel = 1; step(2);
      chk(irq_o == 1, "R9", "empty level irq", irq_o, 1);
      push_pair(32'h1111_2222, 32'h3333_4444); step(2);
      chk(irq_o == 0, "R9", "one pair, empty threshold", irq_o, 0);
      lvl_sel = 0; step(2);
      chk(irq_o == 1, "R9", "one pair, half threshold", irq_o, 1);
      for (int i = 0; i < 4; i++) push_pair(32'h5555_0000 + i, 32'h0000_AAAA + i);
      step(2);
      chk(irq_o == 0, "R9", "five pairs, half threshold", irq_o, 0);
      irq_en = 0; step(2);
      tx_en = 1; step(600);

      chk_on = 0;
      step(2);
      finish_run();
   end
endmodule